// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare Unit

This block compares two IEEE-754 single-precision operands and evaluates one of sixteen predicates. A 4-bit condition selector chooses the predicate. The low three selector bits pick one of eight relations, from "never" to "unordered, less or equal". The top selector bit picks between a quiet form and a signaling form of that relation. The one-bit outcome is written into a dedicated branch-condition word, which downstream sequencing logic tests.

Each compare is started by a single-cycle request strobe. One clock later the unit updates the condition word, pulses `done_o`, and raises `invalid_o` if the compare hit an invalid-operation case. The signaling forms report any NaN as invalid. The quiet forms report only a signaling NaN. A request may be issued on every cycle. The branch-condition word keeps its value between requests.

Top module: `sp_cmp_unit`

## Requirements
- R1: After reset the condition word is all zero, and `done_o` and `invalid_o` are low.
- R2: A request sampled at a rising edge updates the condition word and raises `done_o` at that same edge, so both are visible during the following cycle. `done_o` is high only in the cycle after a request. In a cycle with no request, the condition word holds its value.
- R3: Selector values 0 and 8 ("never") always write a result of 0, whatever the operands.
- R4: The ordered relations are equal (selector 2), less (4) and less-or-equal (6), all taking operand A against operand B. A NaN operand makes less, equal and greater all false. +0 and -0 compare equal. Infinities and denormals are ordered by value.
- R5: The unordered-inclusive relations are: selector 1, true exactly when neither less, equal nor greater holds; selector 3, not (less or greater); selector 5, not (greater or equal); selector 7, not greater.
- R6: Selector values 8 to 15 give the same result as the selector 8 lower, that is, the same relation in its signaling form.
- R7: For a signaling selector (bit 3 set), `invalid_o` is raised when either operand is any NaN: exponent all ones and fraction non-zero.
- R8: For a quiet selector (bit 3 clear), `invalid_o` is raised only when an operand is a signaling NaN, meaning a NaN whose fraction MSB (bit 22) is 0.
- R9: The result occupies bit 0 of the condition word. All higher bits of the word are written as 0.
- R10: `invalid_o` is never high in a cycle where `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Compare request strobe |
| opa_i | input | 32 | Operand A, single-precision |
| opb_i | input | 32 | Operand B, single-precision |
| sel_i | input | 4 | Predicate selector; bit 3 selects the signaling form |
| bcond_o | output | 32 | Branch-condition word; bit 0 holds the last result |
| invalid_o | output | 1 | Invalid-operation flag for the compare just completed |
| done_o | output | 1 | Single-cycle completion pulse |

## Verification
The result write and the invalid-operation report for one compare land in the same cycle. A fault could let one of them lag the other or leak into the next compare. The bench provokes this by sweeping every selector over operand pairs that mix quiet NaNs, signaling NaNs, signed zeros, infinities and denormals, and by issuing compares back to back. In each done cycle it judges the condition bit and the invalid flag against values derived from an integer ordering of the operands.

// File: rtl/sp_cmp_pkg.sv
package sp_cmp_pkg;

    localparam int unsigned NUM_REL = 8;

    typedef enum logic [2:0] {
        REL_NEVER = 3'd0,
        REL_UN    = 3'd1,
        REL_EQ    = 3'd2,
        REL_UEQ   = 3'd3,
        REL_LT    = 3'd4,
        REL_ULT   = 3'd5,
        REL_LE    = 3'd6,
        REL_ULE   = 3'd7
    } rel_sel_e;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } order_t;

    // Evaluate one relation from the three ordering outcomes.
    function automatic logic rel_eval(rel_sel_e r, order_t o);
        logic res;
        case (r)
            REL_NEVER: res = o.lt & o.gt;           // ordering still evaluated, never true
            REL_UN:    res = ~(o.lt | o.eq | o.gt);
            REL_EQ:    res = o.eq;
            REL_UEQ:   res = ~(o.lt | o.gt);
            REL_LT:    res = o.lt;
            REL_ULT:   res = ~(o.gt | o.eq);
            REL_LE:    res = o.lt | o.eq;
            REL_ULE:   res = ~o.gt;
            default:   res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/sp_operand_class.sv
module sp_operand_class #(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 23,
    localparam int unsigned W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] op_i,
    output logic         sign_o,
    output logic [W-2:0] mag_o,
    output logic         zero_o,
    output logic         nan_o,
    output logic         snan_o
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max;
    logic             man_nz;

    always_comb begin
        exp_f   = op_i[W-2 -: EXP_W];
        man_f   = op_i[MAN_W-1:0];
        exp_max = &exp_f;
        man_nz  = |man_f;
        sign_o  = op_i[W-1];
        mag_o   = op_i[W-2:0];
        zero_o  = ~|op_i[W-2:0];
        nan_o   = exp_max & man_nz;
        snan_o  = exp_max & man_nz & ~man_f[MAN_W-1];
    end
endmodule

// File: rtl/sp_order_rel.sv
module sp_order_rel
    import sp_cmp_pkg::*;
#(
    parameter int unsigned MAG_W = 31
) (
    input  logic             a_sign_i,
    input  logic [MAG_W-1:0] a_mag_i,
    input  logic             a_zero_i,
    input  logic             a_nan_i,
    input  logic             b_sign_i,
    input  logic [MAG_W-1:0] b_mag_i,
    input  logic             b_zero_i,
    input  logic             b_nan_i,
    output order_t           ord_o
);
    logic mag_lt;
    logic mag_eq;
    logic both_zero;

    always_comb begin
        mag_lt    = a_mag_i < b_mag_i;
        mag_eq    = a_mag_i == b_mag_i;
        both_zero = a_zero_i & b_zero_i;
        ord_o     = '0;
        if (a_nan_i | b_nan_i) begin
            ord_o = '0;
        end else if (both_zero) begin
            ord_o.eq = 1'b1;
        end else if (a_sign_i != b_sign_i) begin
            ord_o.lt = a_sign_i;
            ord_o.gt = b_sign_i;
        end else if (mag_eq) begin
            ord_o.eq = 1'b1;
        end else begin
            // Same sign: a negative pair reverses magnitude order.
            ord_o.lt = mag_lt ^ a_sign_i;
            ord_o.gt = ~mag_lt ^ a_sign_i;
        end
    end
endmodule

// File: rtl/sp_rel_select.sv
module sp_rel_select
    import sp_cmp_pkg::*;
(
    input  logic [2:0] rel_i,
    input  order_t     ord_i,
    output logic       res_o
);
    logic [NUM_REL-1:0] table_v;

    for (genvar k = 0; k < NUM_REL; k++) begin : g_rel
        assign table_v[k] = rel_eval(rel_sel_e'(k), ord_i);
    end

    assign res_o = table_v[rel_i];
endmodule

// File: rtl/sp_cmp_unit.sv
module sp_cmp_unit
    import sp_cmp_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned MAN_W  = 23,
    parameter int unsigned CREG_W = 32,
    localparam int unsigned W     = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [W-1:0]      opa_i,
    input  logic [W-1:0]      opb_i,
    input  logic [3:0]        sel_i,
    output logic [CREG_W-1:0] bcond_o,
    output logic              invalid_o,
    output logic              done_o
);
    typedef struct packed {
        logic [CREG_W-1:0] bcond;
        logic              inv;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    logic         a_sign, b_sign;
    logic [W-2:0] a_mag, b_mag;
    logic         a_zero, b_zero;
    logic         a_nan, b_nan;
    logic         a_snan, b_snan;
    order_t       ord;
    logic         rel_res;
    logic         sig_mode_d;

    sp_operand_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls_a (
        .op_i   (opa_i),
        .sign_o (a_sign),
        .mag_o  (a_mag),
        .zero_o (a_zero),
        .nan_o  (a_nan),
        .snan_o (a_snan)
    );

    sp_operand_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls_b (
        .op_i   (opb_i),
        .sign_o (b_sign),
        .mag_o  (b_mag),
        .zero_o (b_zero),
        .nan_o  (b_nan),
        .snan_o (b_snan)
    );

    sp_order_rel #(.MAG_W(W-1)) i_order (
        .a_sign_i (a_sign),
        .a_mag_i  (a_mag),
        .a_zero_i (a_zero),
        .a_nan_i  (a_nan),
        .b_sign_i (b_sign),
        .b_mag_i  (b_mag),
        .b_zero_i (b_zero),
        .b_nan_i  (b_nan),
        .ord_o    (ord)
    );

    sp_rel_select i_sel (
        .rel_i (sel_i[2:0]),
        .ord_i (ord),
        .res_o (rel_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.inv   = 1'b0;
        // Signaling mode exists only while a signaling compare is in flight.
        sig_mode_d = req_i & sel_i[3];
        if (req_i) begin
            st_d.bcond = {{(CREG_W-1){1'b0}}, rel_res};
            st_d.done  = 1'b1;
            st_d.inv   = sig_mode_d ? (a_nan | b_nan) : (a_snan | b_snan);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bcond_o   = st_q.bcond;
    assign invalid_o = st_q.inv;
    assign done_o    = st_q.done;
endmodule

// File: rtl/sp_cmp_unit_chk.sv
module sp_cmp_unit_chk #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned MAN_W  = 23,
    parameter int unsigned CREG_W = 32,
    localparam int unsigned W     = 1 + EXP_W + MAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [W-1:0]      opa_i,
    input logic [W-1:0]      opb_i,
    input logic [3:0]        sel_i,
    input logic [CREG_W-1:0] bcond_o,
    input logic              invalid_o,
    input logic              done_o
);
    logic any_nan;
    assign any_nan = ((opa_i[W-2:MAN_W] == '1) && (opa_i[MAN_W-1:0] != '0)) ||
                     ((opb_i[W-2:MAN_W] == '1) && (opb_i[MAN_W-1:0] != '0));

    assert_done_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> done_o);
    assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !done_o);
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(bcond_o));
    assert_never_is_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i[2:0] == 3'd0) |=> !bcond_o[0]);
    assert_nan_not_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && any_nan && sel_i[2:0] == 3'd2) |=> !bcond_o[0]);
    assert_signal_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i[3] && any_nan) |=> invalid_o);
    assert_no_nan_no_inv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !any_nan) |=> !invalid_o);
    assert_upper_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bcond_o[CREG_W-1:1] == '0);
    assert_inv_only_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> done_o);
endmodule

bind sp_cmp_unit sp_cmp_unit_chk #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .CREG_W(CREG_W)
) i_sp_cmp_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .sel_i     (sel_i),
    .bcond_o   (bcond_o),
    .invalid_o (invalid_o),
    .done_o    (done_o)
);

// File: tb/test_sp_cmp_unit.sv
`timescale 1ns/1ps
module test_sp_cmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [3:0]  sel_i = '0;
    logic [31:0] bcond_o;
    logic        invalid_o;
    logic        done_o;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    sp_cmp_unit i_sp_cmp_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .opa_i(opa_i), .opb_i(opb_i),
        .sel_i(sel_i), .bcond_o(bcond_o), .invalid_o(invalid_o), .done_o(done_o)
    );

    localparam int NV = 15;
    logic [31:0] vals [NV];
    initial begin
        vals[0]  = 32'h0000_0000; vals[1]  = 32'h8000_0000;
        vals[2]  = 32'h3f80_0000; vals[3]  = 32'hbf80_0000;
        vals[4]  = 32'h4000_0000; vals[5]  = 32'hc000_0000;
        vals[6]  = 32'h0000_0001; vals[7]  = 32'h8000_0001;
        vals[8]  = 32'h7f80_0000; vals[9]  = 32'hff80_0000;
        vals[10] = 32'h7f7f_ffff; vals[11] = 32'h7fc0_0000;
        vals[12] = 32'h7f80_0001; vals[13] = 32'hffc0_0001;
        vals[14] = 32'h3fc0_0000;
    end

    function automatic bit is_nan(logic [31:0] x);
        return (x[30:23] == 8'hff) && (x[22:0] != 0);
    endfunction

    function automatic bit is_snan(logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction

    // Signed integer rank: magnitude, negated for negative numbers; both zeros rank 0.
    function automatic longint rank(logic [31:0] x);
        longint m;
        m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    function automatic bit exp_result(logic [31:0] a, logic [31:0] b, logic [2:0] r);
        bit lt, eq, gt, un;
        un = is_nan(a) || is_nan(b);
        lt = !un && (rank(a) < rank(b));
        eq = !un && (rank(a) == rank(b));
        gt = !un && (rank(a) > rank(b));
        case (r)
            3'd0: return 1'b0;
            3'd1: return un;
            3'd2: return eq;
            3'd3: return un | eq;
            3'd4: return lt;
            3'd5: return un | lt;
            3'd6: return lt | eq;
            default: return un | lt | eq;
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic string req_tag(logic [3:0] s);
        if (s[3]) return "R6";
        if (s[2:0] == 3'd0) return "R3";
        if (s[0]) return "R5";
        return "R4";
    endfunction

    task automatic judge(logic [31:0] a, logic [31:0] b, logic [3:0] s);
        logic [31:0] expw;
        bit          expi;
        expw = {31'b0, exp_result(a, b, s[2:0])};
        expi = s[3] ? (is_nan(a) || is_nan(b)) : (is_snan(a) || is_snan(b));
        check(done_o === 1'b1, "R2 done", {31'b0, done_o}, 32'd1);
        check(bcond_o === expw, req_tag(s), bcond_o, expw);
        check(invalid_o === expi, s[3] ? "R7" : "R8", {31'b0, invalid_o}, {31'b0, expi});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check(bcond_o === 32'd0, "R1 bcond", bcond_o, 32'd0);
        check(done_o === 1'b0 && invalid_o === 1'b0, "R1 flags",
              {30'b0, done_o, invalid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Full sweep: one request, then an idle cycle that checks hold.
        for (int s = 0; s < 16; s++) begin
            for (int i = 0; i < NV; i++) begin
                for (int j = 0; j < NV; j++) begin
                    req_i = 1'b1; opa_i = vals[i]; opb_i = vals[j]; sel_i = 4'(s);
                    @(negedge clk);
                    req_i = 1'b0;
                    judge(vals[i], vals[j], 4'(s));
                    held = bcond_o;
                    opa_i = vals[(i + 3) % NV]; sel_i = 4'(15 - s);
                    @(negedge clk);
                    // R2 idle: word holds, no done, no invalid (R10)
                    check(bcond_o === held && done_o === 1'b0, "R2 hold", bcond_o, held);
                    check(invalid_o === 1'b0, "R10", {31'b0, invalid_o}, 32'd0);
                end
            end
        end

        // Back-to-back requests: each done cycle carries its own result and flag.
        for (int k = 0; k < 64; k++) begin
            req_i = 1'b1;
            opa_i = vals[k % NV]; opb_i = vals[(k * 7 + 2) % NV]; sel_i = 4'((k * 5) % 16);
            @(negedge clk);
            judge(vals[k % NV], vals[(k * 7 + 2) % NV], 4'((k * 5) % 16));
        end
        req_i = 1'b0;
        @(negedge clk);
        check(done_o === 1'b0, "R2 end", {31'b0, done_o}, 32'd0);

        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule